// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the 20-bit instruction fetch address of a small 8-bit processor. The address is a 6-bit program page on top of a 14-bit in-page counter. An instruction decoder gives it one-cycle command strobes with their operand fields: advance, conditional skip, short branch, jump, call, the three return kinds and interrupt entry. The block moves the counter, and the page where needed. A separate 6-bit page register, loaded by software, reaches the program page only through a jump, a call, interrupt entry or a page restore.

Calls, interrupt entry and returns move bytes between the program state and a byte-wide stack RAM through a simple synchronous port. The port makes one access per clock. An 8-bit stack pointer addresses the RAM and the stack grows downward. A small sequencer walks the bytes of a multi-byte transfer and holds `busy_o` high while it runs. The decoder sends no new command while busy is high. Commands that arrive anyway are dropped.

Top module: `prog_seq_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `fetch_addr_o`, `sp_o` and `page_reg_o` read zero, and `busy_o`, `ram_we_o` and `ram_re_o` are low.
- R2: An advance adds one to the 14-bit counter (bits 13:0 of `fetch_addr_o`). From 3FFFh the counter wraps to 0000h, and the page bits 19:14 do not change.
- R3: `page_reg_o` bits 7:6 always read zero. A page write keeps only `page_d_i[5:0]`. A jump loads `tgt_i` into the counter and the page register into the program page. A page write issued in the same cycle as a jump or call is the value committed.
- R4: A call writes the counter low byte at address SP and then the counter high byte at SP-1. The high byte carries zeros in bits 7:6. When the page register differs from the program page, the page byte follows at SP-2. SP drops by one per write, and the counter and page are then loaded as for a jump.
- R5: A short branch replaces counter bits 7:0 with `br_ofs_i` and keeps bits 13:8. A skip adds 2 to the counter, wrapping in 14 bits, when `skip_cond_i` is high, and does nothing when it is low.
- R6: Interrupt entry sets the program page and the page register to 3. It loads the counter from `irq_src_i`: code 0 gives 3FF0h, 1 gives 3FE0h, 2 gives 3FD0h and 3 gives 3FC0h. It then writes counter low, counter high, old program page and `stat_i` to SP, SP-1, SP-2 and SP-3.
- R7: A short return reads SP+1 into counter bits 13:8 and then SP+2 into bits 7:0. SP ends two higher.
- R8: A long return reads the page byte, then counter high, then counter low. The page byte goes into both the program page and the page register. Return-from-interrupt first reads a status byte, shows it on `stat_o` with a one-cycle `stat_vld_o`, and then does the same as a long return.
- R9: The RAM port never reads and writes in the same cycle. A push of n bytes keeps `busy_o` high for n cycles and a pop of n bytes for n+1 cycles. Any command, page write or SP load presented while `busy_o` is high has no effect.
- R10: When several commands are presented together, only the highest-priority one acts. The order from highest is interrupt, return-from-interrupt, long return, short return, call, jump, branch, skip, advance.
- R11: The RAM returns read data on `ram_rdata_i` in the cycle after `ram_re_o` is high. An SP load sets `sp_o` to `sp_d_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance the counter by one |
| skip_i | input | 1 | Conditional skip |
| skip_cond_i | input | 1 | Skip condition |
| br_i | input | 1 | Short branch |
| br_ofs_i | input | 8 | Branch low byte |
| jmp_i | input | 1 | Jump |
| call_i | input | 1 | Call |
| tgt_i | input | 14 | Jump or call target |
| ret_i | input | 1 | Short return |
| retl_i | input | 1 | Long return |
| reti_i | input | 1 | Return from interrupt |
| irq_i | input | 1 | Interrupt entry |
| irq_src_i | input | 2 | Interrupt source code |
| stat_i | input | 8 | Status byte to save on interrupt entry |
| page_we_i | input | 1 | Page register write |
| page_d_i | input | 8 | Page register data |
| sp_we_i | input | 1 | Stack pointer load |
| sp_d_i | input | 8 | Stack pointer data |
| ram_re_o | output | 1 | Stack RAM read |
| ram_we_o | output | 1 | Stack RAM write |
| ram_addr_o | output | 8 | Stack RAM address |
| ram_wdata_o | output | 8 | Stack RAM write data |
| ram_rdata_i | input | 8 | Stack RAM read data, one cycle after read |
| fetch_addr_o | output | 20 | Page and counter fetch address |
| page_reg_o | output | 8 | Page register |
| sp_o | output | 8 | Stack pointer |
| stat_o | output | 8 | Restored status byte |
| stat_vld_o | output | 1 | Restored status valid |
| busy_o | output | 1 | Stack transfer in progress |

## Verification
A page write and a jump or call can land in the same cycle. The bench raises both strobes together with a page value that differs from the current program page. It then checks that the new page becomes the program page and that the call pushes the extra page byte. An interrupt can also meet an advance in the same cycle. The bench presents both and expects the vector address and a four-byte push, with no increment. A jump sent during the push must leave the vector address unchanged.

// File: rtl/pas_pkg.sv
package pas_pkg;

    localparam int PC_W   = 14;
    localparam int PG_W   = 6;
    localparam int DW     = 8;
    localparam int SP_W   = 8;
    localparam int FA_W   = PC_W + PG_W;
    localparam int PCH_W  = PC_W - DW;
    localparam int MAXB   = 4;
    localparam int CNT_W  = $clog2(MAXB + 1);

    localparam logic [PG_W-1:0] VEC_PAGE = PG_W'(3);
    localparam logic [PC_W-1:0] VEC_TOP  = PC_W'(14'h3FF0);

    typedef enum logic [3:0] {
        OP_NONE, OP_ADV, OP_SKIP, OP_BR, OP_JMP,
        OP_CALL, OP_RET, OP_RETL, OP_RETI, OP_IRQ
    } op_e;

    typedef enum logic [1:0] {
        BK_PCL  = 2'd0,
        BK_PCH  = 2'd1,
        BK_PAGE = 2'd2,
        BK_STAT = 2'd3
    } byte_e;

    typedef enum logic [1:0] {SQ_IDLE, SQ_PUSH, SQ_POP, SQ_DRAIN} seq_e;

    typedef struct packed {
        logic [PG_W-1:0] page;
        logic [PC_W-1:0] pc;
    } faddr_t;

    typedef struct packed {
        logic          vld;
        byte_e         kind;
        logic [DW-1:0] data;
    } rest_t;

    function automatic op_e pick_op(
        input logic irq, input logic reti, input logic retl,
        input logic ret, input logic call, input logic jmp,
        input logic br,  input logic skip, input logic adv);
        if (irq)       return OP_IRQ;
        else if (reti) return OP_RETI;
        else if (retl) return OP_RETL;
        else if (ret)  return OP_RET;
        else if (call) return OP_CALL;
        else if (jmp)  return OP_JMP;
        else if (br)   return OP_BR;
        else if (skip) return OP_SKIP;
        else if (adv)  return OP_ADV;
        return OP_NONE;
    endfunction

    function automatic logic [PC_W-1:0] vec_ofs(input logic [1:0] src);
        return VEC_TOP - PC_W'({src, 4'h0});
    endfunction

endpackage

// File: rtl/pas_pc_unit.sv
module pas_pc_unit
    import pas_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  op_e             op,
    input  logic [PC_W-1:0] tgt,
    input  logic [DW-1:0]   br_ofs,
    input  logic            skip_cond,
    input  logic [1:0]      irq_src,
    input  logic            page_we,
    input  logic [DW-1:0]   page_d,
    input  rest_t           rest,
    output faddr_t          fa,
    output logic [DW-1:0]   preg_o,
    output logic            far_o
);
    logic [PG_W-1:0] page_q;
    logic [PC_W-1:0] pc_q;
    logic [PG_W-1:0] preg_q;
    logic [PG_W-1:0] eff_preg;
    logic            unused_page_hi;

    assign unused_page_hi = ^page_d[DW-1:PG_W];
    assign eff_preg = page_we ? page_d[PG_W-1:0] : preg_q;
    assign far_o    = (eff_preg != page_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            pc_q   <= '0;
            preg_q <= '0;
        end else begin
            if (page_we)
                preg_q <= page_d[PG_W-1:0];
            case (op)
                OP_ADV:  pc_q <= pc_q + PC_W'(1);
                OP_SKIP: if (skip_cond) pc_q <= pc_q + PC_W'(2);
                OP_BR:   pc_q[DW-1:0] <= br_ofs;
                OP_JMP, OP_CALL: begin
                    page_q <= eff_preg;
                    pc_q   <= tgt;
                end
                OP_IRQ: begin
                    page_q <= VEC_PAGE;
                    preg_q <= VEC_PAGE;
                    pc_q   <= vec_ofs(irq_src);
                end
                default: ;
            endcase
            if (rest.vld) begin
                case (rest.kind)
                    BK_PAGE: begin
                        page_q <= rest.data[PG_W-1:0];
                        preg_q <= rest.data[PG_W-1:0];
                    end
                    BK_PCH:  pc_q[PC_W-1:DW] <= rest.data[PCH_W-1:0];
                    BK_PCL:  pc_q[DW-1:0]    <= rest.data;
                    default: ;
                endcase
            end
        end
    end

    assign fa.page = page_q;
    assign fa.pc   = pc_q;
    assign preg_o  = {{(DW-PG_W){1'b0}}, preg_q};

endmodule

// File: rtl/pas_stack_seq.sv
module pas_stack_seq
    import pas_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  op_e             op,
    input  logic            far,
    input  logic            sp_we,
    input  logic [SP_W-1:0] sp_d,
    input  faddr_t          fa_now,
    input  logic [DW-1:0]   stat_in,
    input  logic [DW-1:0]   ram_rdata,
    output logic            ram_re,
    output logic            ram_we,
    output logic [SP_W-1:0] ram_addr,
    output logic [DW-1:0]   ram_wdata,
    output rest_t           rest,
    output logic            busy,
    output logic [SP_W-1:0] sp_o
);
    seq_e             st_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SP_W-1:0]  sp_q;
    logic [DW-1:0]    sv_q [MAXB];
    logic             pend_q;
    byte_e            ptag_q;
    logic [CNT_W-1:0] tag_w;
    logic             last_w;

    assign tag_w  = cnt_q - CNT_W'(1) - idx_q;
    assign last_w = (idx_q == cnt_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            idx_q  <= '0;
            cnt_q  <= '0;
            sp_q   <= '0;
            pend_q <= 1'b0;
            ptag_q <= BK_PCL;
            for (int i = 0; i < MAXB; i++) sv_q[i] <= '0;
        end else begin
            pend_q <= 1'b0;
            case (st_q)
                SQ_IDLE: begin
                    idx_q <= '0;
                    case (op)
                        OP_CALL, OP_IRQ: begin
                            st_q     <= SQ_PUSH;
                            sv_q[0]  <= fa_now.pc[DW-1:0];
                            sv_q[1]  <= DW'(fa_now.pc[PC_W-1:DW]);
                            sv_q[2]  <= DW'(fa_now.page);
                            sv_q[3]  <= stat_in;
                            if (op == OP_IRQ) cnt_q <= CNT_W'(4);
                            else              cnt_q <= far ? CNT_W'(3) : CNT_W'(2);
                        end
                        OP_RET:  begin st_q <= SQ_POP; cnt_q <= CNT_W'(2); end
                        OP_RETL: begin st_q <= SQ_POP; cnt_q <= CNT_W'(3); end
                        OP_RETI: begin st_q <= SQ_POP; cnt_q <= CNT_W'(4); end
                        default: if (sp_we) sp_q <= sp_d;
                    endcase
                end
                SQ_PUSH: begin
                    sp_q  <= sp_q - SP_W'(1);
                    idx_q <= idx_q + CNT_W'(1);
                    if (last_w) st_q <= SQ_IDLE;
                end
                SQ_POP: begin
                    sp_q   <= sp_q + SP_W'(1);
                    idx_q  <= idx_q + CNT_W'(1);
                    pend_q <= 1'b1;
                    ptag_q <= byte_e'(tag_w[1:0]);
                    if (last_w) st_q <= SQ_DRAIN;
                end
                SQ_DRAIN: st_q <= SQ_IDLE;
                default:  st_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ram_we    = (st_q == SQ_PUSH);
        ram_re    = (st_q == SQ_POP);
        ram_addr  = ram_re ? sp_q + SP_W'(1) : sp_q;
        ram_wdata = ram_we ? sv_q[idx_q[1:0]] : '0;
    end

    assign rest.vld  = pend_q;
    assign rest.kind = ptag_q;
    assign rest.data = ram_rdata;
    assign busy      = (st_q != SQ_IDLE);
    assign sp_o      = sp_q;

endmodule

// File: rtl/prog_seq_top.sv
module prog_seq_top
    import pas_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        adv_i,
    input  logic        skip_i,
    input  logic        skip_cond_i,
    input  logic        br_i,
    input  logic [7:0]  br_ofs_i,
    input  logic        jmp_i,
    input  logic        call_i,
    input  logic [13:0] tgt_i,
    input  logic        ret_i,
    input  logic        retl_i,
    input  logic        reti_i,
    input  logic        irq_i,
    input  logic [1:0]  irq_src_i,
    input  logic [7:0]  stat_i,
    input  logic        page_we_i,
    input  logic [7:0]  page_d_i,
    input  logic        sp_we_i,
    input  logic [7:0]  sp_d_i,
    output logic        ram_re_o,
    output logic        ram_we_o,
    output logic [7:0]  ram_addr_o,
    output logic [7:0]  ram_wdata_o,
    input  logic [7:0]  ram_rdata_i,
    output logic [19:0] fetch_addr_o,
    output logic [7:0]  page_reg_o,
    output logic [7:0]  sp_o,
    output logic [7:0]  stat_o,
    output logic        stat_vld_o,
    output logic        busy_o
);
    op_e    op_w;
    logic   busy_w;
    logic   far_w;
    faddr_t fa_w;
    rest_t  rest_w;

    assign op_w = busy_w ? OP_NONE :
                  pick_op(irq_i, reti_i, retl_i, ret_i, call_i, jmp_i, br_i, skip_i, adv_i);

    pas_pc_unit u_pc (
        .clk       (clk),
        .rst       (rst),
        .op        (op_w),
        .tgt       (tgt_i),
        .br_ofs    (br_ofs_i),
        .skip_cond (skip_cond_i),
        .irq_src   (irq_src_i),
        .page_we   (page_we_i & ~busy_w),
        .page_d    (page_d_i),
        .rest      (rest_w),
        .fa        (fa_w),
        .preg_o    (page_reg_o),
        .far_o     (far_w)
    );

    pas_stack_seq u_stk (
        .clk       (clk),
        .rst       (rst),
        .op        (op_w),
        .far       (far_w),
        .sp_we     (sp_we_i & ~busy_w),
        .sp_d      (sp_d_i),
        .fa_now    (fa_w),
        .stat_in   (stat_i),
        .ram_rdata (ram_rdata_i),
        .ram_re    (ram_re_o),
        .ram_we    (ram_we_o),
        .ram_addr  (ram_addr_o),
        .ram_wdata (ram_wdata_o),
        .rest      (rest_w),
        .busy      (busy_w),
        .sp_o      (sp_o)
    );

    assign fetch_addr_o = fa_w;
    assign busy_o       = busy_w;
    assign stat_vld_o   = rest_w.vld && (rest_w.kind == BK_STAT);
    assign stat_o       = stat_vld_o ? rest_w.data : '0;

endmodule

// File: rtl/prog_seq_checker.sv
module prog_seq_checker (
    input logic        clk,
    input logic        rst,
    input logic        adv_i,
    input logic        skip_i,
    input logic        br_i,
    input logic        jmp_i,
    input logic        call_i,
    input logic        ret_i,
    input logic        retl_i,
    input logic        reti_i,
    input logic        irq_i,
    input logic        ram_re_o,
    input logic        ram_we_o,
    input logic [7:0]  sp_o,
    input logic [19:0] fetch_addr_o,
    input logic [7:0]  page_reg_o,
    input logic        busy_o
);
    logic other_cmd;
    assign other_cmd = skip_i | br_i | jmp_i | call_i | ret_i | retl_i | reti_i | irq_i;

    assert_one_access_R9: assert property (@(posedge clk) disable iff (rst)
        !(ram_re_o && ram_we_o));

    assert_push_dec_R4: assert property (@(posedge clk) disable iff (rst)
        ram_we_o |=> sp_o == $past(sp_o) - 8'd1);

    assert_pop_inc_R7: assert property (@(posedge clk) disable iff (rst)
        ram_re_o |=> sp_o == $past(sp_o) + 8'd1);

    assert_adv_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && adv_i && !other_cmd) |=>
            (fetch_addr_o[13:0] == $past(fetch_addr_o[13:0]) + 14'd1) &&
            $stable(fetch_addr_o[19:14]));

    assert_vec_page_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && irq_i) |=> (fetch_addr_o[19:14] == 6'd3) && (page_reg_o == 8'd3));

    assert_page_hi_R3: assert property (@(posedge clk) disable iff (rst)
        page_reg_o[7:6] == 2'b00);

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !ram_re_o && !ram_we_o) |=> $stable(fetch_addr_o[19:14]) || !busy_o);

endmodule

bind prog_seq_top prog_seq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .adv_i        (adv_i),
    .skip_i       (skip_i),
    .br_i         (br_i),
    .jmp_i        (jmp_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .retl_i       (retl_i),
    .reti_i       (reti_i),
    .irq_i        (irq_i),
    .ram_re_o     (ram_re_o),
    .ram_we_o     (ram_we_o),
    .sp_o         (sp_o),
    .fetch_addr_o (fetch_addr_o),
    .page_reg_o   (page_reg_o),
    .busy_o       (busy_o)
);

// File: tb/prog_seq_top_test.sv
`timescale 1ns/1ps
module prog_seq_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_i = 0, skip_i = 0, skip_cond_i = 0, br_i = 0;
    logic [7:0]  br_ofs_i = 0;
    logic        jmp_i = 0, call_i = 0;
    logic [13:0] tgt_i = 0;
    logic        ret_i = 0, retl_i = 0, reti_i = 0, irq_i = 0;
    logic [1:0]  irq_src_i = 0;
    logic [7:0]  stat_i = 0;
    logic        page_we_i = 0;
    logic [7:0]  page_d_i = 0;
    logic        sp_we_i = 0;
    logic [7:0]  sp_d_i = 0;
    logic        ram_re_o, ram_we_o;
    logic [7:0]  ram_addr_o, ram_wdata_o;
    logic [7:0]  ram_rdata_i = 0;
    logic [19:0] fetch_addr_o;
    logic [7:0]  page_reg_o, sp_o, stat_o;
    logic        stat_vld_o, busy_o;

    logic [7:0]  mem [256];
    logic [16:0] expq [$];
    int          total = 0;
    int          bad = 0;
    int          stat_cnt = 0;
    logic [7:0]  stat_seen = 0;
    int          busy_cyc = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    prog_seq_top uut (.*);

    always @(posedge clk) begin
        if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
        if (ram_re_o) ram_rdata_i <= mem[ram_addr_o];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every RAM access is compared with the next expected item
    always @(negedge clk) begin
        if (!rst && (ram_we_o || ram_re_o)) begin
            if (expq.size() == 0) begin
                total++; bad++;
                $display("FAIL R9 unexpected access actual=%0h expected=none",
                         {ram_we_o, ram_addr_o, ram_wdata_o});
            end else begin
                logic [16:0] e;
                e = expq.pop_front();
                check(e[16] ? "R4/R6 push" : "R7/R8 pop",
                      {ram_we_o, ram_addr_o, (e[16] ? ram_wdata_o : 8'h00)}, e);
            end
        end
        if (!rst && stat_vld_o) begin
            stat_cnt++;
            stat_seen = stat_o;
        end
    end

    task automatic exp_wr(input logic [7:0] a, input logic [7:0] d);
        expq.push_back({1'b1, a, d});
    endtask
    task automatic exp_rd(input logic [7:0] a);
        expq.push_back({1'b0, a, 8'h00});
    endtask

    task automatic clear_cmds();
        adv_i = 0; skip_i = 0; br_i = 0; jmp_i = 0; call_i = 0;
        ret_i = 0; retl_i = 0; reti_i = 0; irq_i = 0;
        page_we_i = 0; sp_we_i = 0;
    endtask

    task automatic pulse();
        @(negedge clk);
        clear_cmds();
    endtask

    task automatic wait_idle();
        busy_cyc = 0;
        while (busy_o) begin
            busy_cyc++;
            @(negedge clk);
        end
    endtask

    task automatic do_jmp(input logic [13:0] t);
        jmp_i = 1; tgt_i = t; pulse(); wait_idle();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 fetch", fetch_addr_o, 0);
        check("R1 sp", sp_o, 0);
        check("R1 busy/ram", {busy_o, ram_we_o, ram_re_o, page_reg_o}, 0);
        rst = 0;
        @(negedge clk);
        check("R1 after release", {fetch_addr_o, sp_o, busy_o}, 0);

        // R11 stack pointer load
        sp_we_i = 1; sp_d_i = 8'hFF; pulse();
        check("R11 sp load", sp_o, 8'hFF);

        // R2 advance and wrap
        repeat (3) begin adv_i = 1; pulse(); end
        check("R2 advance", fetch_addr_o, 20'h00003);
        do_jmp(14'h3FFF);
        adv_i = 1; pulse();
        check("R2 wrap", fetch_addr_o, 20'h00000);

        // R3 page register masking and jump
        page_we_i = 1; page_d_i = 8'hC5; pulse();
        check("R3 page mask", page_reg_o, 8'h05);
        do_jmp(14'h1234);
        check("R3 jump", fetch_addr_o, {6'd5, 14'h1234});

        // R5 branch and skips
        br_i = 1; br_ofs_i = 8'hAB; pulse();
        check("R5 branch", fetch_addr_o, {6'd5, 14'h12AB});
        skip_i = 1; skip_cond_i = 1; pulse();
        check("R5 skip taken", fetch_addr_o, {6'd5, 14'h12AD});
        skip_i = 1; skip_cond_i = 0; pulse();
        check("R5 skip not taken", fetch_addr_o, {6'd5, 14'h12AD});

        // R4 short call (page register equals program page)
        exp_wr(8'hFF, 8'hAD); exp_wr(8'hFE, 8'h12);
        call_i = 1; tgt_i = 14'h0100; pulse(); wait_idle();
        check("R9 short call busy", busy_cyc, 2);
        check("R4 short call addr", fetch_addr_o, {6'd5, 14'h0100});
        check("R4 short call sp", sp_o, 8'hFD);

        // R3/R4 page write in the same cycle as call -> far call
        exp_wr(8'hFD, 8'h00); exp_wr(8'hFC, 8'h01); exp_wr(8'hFB, 8'h05);
        call_i = 1; tgt_i = 14'h2000; page_we_i = 1; page_d_i = 8'h09; pulse(); wait_idle();
        check("R9 far call busy", busy_cyc, 3);
        check("R3 same-cycle page commit", fetch_addr_o, {6'd9, 14'h2000});
        check("R4 far call sp", sp_o, 8'hFA);

        // R6/R10 interrupt with advance, then R9 jump during busy ignored
        exp_wr(8'hFA, 8'h00); exp_wr(8'hF9, 8'h20); exp_wr(8'hF8, 8'h09); exp_wr(8'hF7, 8'hA5);
        irq_i = 1; adv_i = 1; irq_src_i = 2'd1; stat_i = 8'hA5; pulse();
        jmp_i = 1; tgt_i = 14'h0000; page_we_i = 1; page_d_i = 8'h22; pulse();
        wait_idle();
        check("R10 irq over advance", fetch_addr_o, {6'd3, 14'h3FE0});
        check("R9 ignored while busy", page_reg_o, 8'h03);
        check("R6 irq sp", sp_o, 8'hF6);

        // R8 return from interrupt
        exp_rd(8'hF7); exp_rd(8'hF8); exp_rd(8'hF9); exp_rd(8'hFA);
        stat_cnt = 0;
        reti_i = 1; pulse(); wait_idle();
        check("R9 reti busy", busy_cyc, 5);
        check("R8 reti addr", fetch_addr_o, {6'd9, 14'h2000});
        check("R8 reti page reg", page_reg_o, 8'h09);
        check("R8 status", {stat_cnt[7:0], stat_seen}, {8'd1, 8'hA5});

        // R8 long return
        exp_rd(8'hFB); exp_rd(8'hFC); exp_rd(8'hFD);
        retl_i = 1; pulse(); wait_idle();
        check("R8 long return", fetch_addr_o, {6'd5, 14'h0100});
        check("R8 long return page reg", page_reg_o, 8'h05);

        // R7 short return
        exp_rd(8'hFE); exp_rd(8'hFF);
        ret_i = 1; pulse(); wait_idle();
        check("R7 short return", fetch_addr_o, {6'd5, 14'h12AD});
        check("R7 sp", sp_o, 8'hFF);

        // R6 remaining vectors, each undone by return from interrupt
        for (int s = 0; s < 4; s++) begin
            if (s != 1) begin
                logic [13:0] v;
                v = 14'h3FF0 - 14'(s * 16);
                exp_wr(8'hFF, 8'hAD); exp_wr(8'hFE, 8'h12); exp_wr(8'hFD, 8'h05);
                exp_wr(8'hFC, 8'(s));
                irq_i = 1; irq_src_i = 2'(s); stat_i = 8'(s); pulse(); wait_idle();
                check("R6 vector", fetch_addr_o, {6'd3, v});
                exp_rd(8'hFC); exp_rd(8'hFD); exp_rd(8'hFE); exp_rd(8'hFF);
                reti_i = 1; pulse(); wait_idle();
                check("R8 back from vector", {fetch_addr_o, stat_seen}, {6'd5, 14'h12AD, 8'(s)});
            end
        end

        // R10 jump beats branch and advance
        jmp_i = 1; br_i = 1; adv_i = 1; tgt_i = 14'h0777; br_ofs_i = 8'h11; pulse();
        check("R10 jump priority", fetch_addr_o, {6'd5, 14'h0777});

        // R5 skip wraps in 14 bits
        do_jmp(14'h3FFF);
        skip_i = 1; skip_cond_i = 1; pulse();
        check("R5 skip wrap", fetch_addr_o, {6'd5, 14'h0001});

        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", expq.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule